// File: doc/BRIEF.md
# CAN message buffer fragmenter

This block takes a packet arriving one byte at a time and writes it into the transmit buffer of a CAN controller. The packet begins with an 8-byte message header, and payload follows it. The buffer has a fixed, programmed size. When the payload does not fit in one buffer, the block cuts the packet into fragments. Each fragment starts with the same header, and the block replays that header from its own storage, so the source sends the header only once.

Both data interfaces use valid/ready handshakes. A write to the buffer takes place on a cycle where `wr_valid` and `wr_ready` are both high. While a write is pending, the sink may hold `wr_ready` low for any number of cycles. During that stall, the offset and data stay stable, and the block takes no further input byte.

An input byte is accepted only when it is being written in the same cycle. This means back-pressure from the buffer passes straight through to `in_ready`. The exception is header replay: during replay, `in_ready` stays low. One cycle after the last byte of each fragment is written, `frag_done` pulses. The controller can then launch that buffer.

Top module: `canfrag_top`

## Requirements
- R1: After reset, `wr_valid` and `frag_done` are low and `next_offset_o` is 0.
- R2: The block holds a pending write while `wr_ready` is low. It keeps `wr_valid` high and holds `wr_offset` and `wr_data` unchanged until the write is accepted. No input byte is accepted in a cycle where the write is not.
- R3: The size in use is `buf_size_i` limited to the range 16 to 72 bytes, header included. A value below 16 acts as 16, and a value above 72 acts as 72.
- R4: The first fragment of a packet holds the incoming bytes in arrival order at offsets 0, 1, 2 and upward. Offsets 0 to 7 carry the header, and offsets 8 up to size−1 carry payload.
- R5: After offset size−1 is written, `frag_done` is high for the next cycle and the write offset returns to 0.
- R6: Every later fragment of the same packet starts with the stored header at offsets 0 to 7, in its original byte order. `in_ready` stays low during those 8 writes. Payload then resumes at offset 8.
- R7: The byte flagged by `in_last` ends its fragment, even when that fragment is short, and `frag_done` pulses on the next cycle. When the last byte lands exactly at offset size−1, no header replay follows. The next packet's header is captured afresh.
- R8: The size is sampled with the first byte of a packet. Changes to `buf_size_i` during that packet do not affect its fragmentation.
- R9: A packet shorter than 8 bytes is written as-is from offset 0 and ends with one `frag_done` pulse.
- R10: `next_offset_o` shows the buffer offset the next write will use. It equals `wr_offset` of a pending write and is 0 after each fragment ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_size_i | input | 12 | Programmed buffer size in bytes, header included |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a packet |
| wr_valid | output | 1 | Buffer write pending |
| wr_ready | input | 1 | Buffer accepts the write |
| wr_offset | output | 7 | Byte offset inside the transmit buffer |
| wr_data | output | 8 | Byte to write |
| frag_done | output | 1 | One-cycle pulse after a fragment's final byte is written |
| next_offset_o | output | 7 | Offset of the next write (debug view) |

## Verification
Several properties are checked by the assertions on every cycle:
- a stalled write stays frozen;
- the offset stays below the size in use, and that size stays within 16 to 72 and does not change during a packet;
- the offset advances by one on each accepted write inside a fragment;
- every `frag_done` follows an accepted write and leaves the offset at 0.

Other behaviour can only be shown by the bench's scenarios, which compare every write against a model of the fragment layout:
- whether the replayed header bytes match the first fragment's header;
- where fragment boundaries fall for clamped sizes;
- the end-of-packet priority at a full buffer;
- the capture of a fresh header for the next packet.

// File: rtl/canfrag_pkg.sv
package canfrag_pkg;
  // Source of the byte currently presented on the buffer write port.
  typedef enum logic [1:0] {
    PH_HDR = 2'd0,  // header arriving from the stream (first fragment)
    PH_PAY = 2'd1,  // payload arriving from the stream
    PH_RPL = 2'd2   // header replayed from storage (later fragments)
  } phase_e;
endpackage

// File: rtl/canfrag_size_clamp.sv
module canfrag_size_clamp #(
  parameter int SIZE_W   = 12,
  parameter int MIN_SIZE = 16,
  parameter int MAX_SIZE = 72,
  parameter int CW       = $clog2(MAX_SIZE + 1)
) (
  input  logic [SIZE_W-1:0] raw_i,
  output logic [CW-1:0]     size_o
);
  always_comb begin
    if (raw_i < SIZE_W'(MIN_SIZE))      size_o = CW'(MIN_SIZE);
    else if (raw_i > SIZE_W'(MAX_SIZE)) size_o = CW'(MAX_SIZE);
    else                                size_o = raw_i[CW-1:0];
  end
endmodule

// File: rtl/canfrag_hdr_store.sv
module canfrag_hdr_store #(
  parameter int HDR_BYTES = 8,
  parameter int IW        = $clog2(HDR_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_byte_i,
  input  logic          clr_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_byte_o
);
  logic [7:0] slot_q [HDR_BYTES];

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q[g] <= '0;
      else if (clr_i)                               slot_q[g] <= '0;
      else if (we_i && (wr_idx_i == IW'(g)))        slot_q[g] <= wr_byte_i;
    end
  end

  assign rd_byte_o = slot_q[rd_idx_i];
endmodule

// File: rtl/canfrag_seq.sv
module canfrag_seq
  import canfrag_pkg::*;
#(
  parameter int HDR_BYTES = 8,
  parameter int MIN_SIZE  = 16,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] size_now_i,
  input  logic          in_valid_i,
  input  logic          in_last_i,
  input  logic          wr_ready_i,
  output phase_e        phase_o,
  output logic [CW-1:0] off_o,
  output logic [CW-1:0] size_eff_o,
  output logic          in_pkt_o,
  output logic          in_ready_o,
  output logic          wr_valid_o,
  output logic          hdr_we_o,
  output logic          hdr_clr_o,
  output logic          done_o
);
  phase_e        phase_q;
  logic [CW-1:0] off_q;
  logic [CW-1:0] size_q;
  logic          in_pkt_q;
  logic          done_q;

  logic stream_ph, fire, take, pkt_end, frag_full;

  assign size_eff_o = in_pkt_q ? size_q : size_now_i;
  assign stream_ph  = (phase_q != PH_RPL);
  assign wr_valid_o = stream_ph ? in_valid_i : 1'b1;
  assign in_ready_o = stream_ph & wr_ready_i;
  assign fire       = wr_valid_o & wr_ready_i;
  assign take       = fire & stream_ph;
  assign pkt_end    = take & in_last_i;
  assign frag_full  = fire & (off_q == (size_eff_o - CW'(1)));
  assign hdr_we_o   = take & (phase_q == PH_HDR);
  assign hdr_clr_o  = pkt_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HDR;
      off_q    <= '0;
      size_q   <= CW'(MIN_SIZE);
      in_pkt_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= pkt_end | frag_full;
      if (take && !in_pkt_q) begin
        in_pkt_q <= 1'b1;
        size_q   <= size_now_i;
      end
      if (pkt_end) begin
        in_pkt_q <= 1'b0;
        phase_q  <= PH_HDR;
        off_q    <= '0;
      end else if (frag_full) begin
        phase_q <= PH_RPL;
        off_q   <= '0;
      end else if (fire) begin
        off_q <= off_q + CW'(1);
        if ((phase_q != PH_PAY) && (off_q == CW'(HDR_BYTES - 1))) phase_q <= PH_PAY;
      end
    end
  end

  assign phase_o  = phase_q;
  assign off_o    = off_q;
  assign in_pkt_o = in_pkt_q;
  assign done_o   = done_q;
endmodule

// File: rtl/canfrag_top.sv
module canfrag_top
  import canfrag_pkg::*;
#(
  parameter int SIZE_W    = 12,
  parameter int HDR_BYTES = 8,
  parameter int MIN_SIZE  = 16,
  parameter int MAX_SIZE  = 72,
  localparam int CW       = $clog2(MAX_SIZE + 1),
  localparam int IW       = $clog2(HDR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] buf_size_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CW-1:0]     wr_offset,
  output logic [7:0]        wr_data,
  output logic              frag_done,
  output logic [CW-1:0]     next_offset_o
);
  logic [CW-1:0] size_now, size_eff, off_q;
  logic          in_pkt, hdr_we, hdr_clr;
  logic [7:0]    hdr_byte;
  phase_e        phase;

  canfrag_size_clamp #(
    .SIZE_W(SIZE_W), .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .CW(CW)
  ) u_clamp (
    .raw_i (buf_size_i),
    .size_o(size_now)
  );

  canfrag_seq #(
    .HDR_BYTES(HDR_BYTES), .MIN_SIZE(MIN_SIZE), .CW(CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_now_i(size_now),
    .in_valid_i(in_valid),
    .in_last_i (in_last),
    .wr_ready_i(wr_ready),
    .phase_o   (phase),
    .off_o     (off_q),
    .size_eff_o(size_eff),
    .in_pkt_o  (in_pkt),
    .in_ready_o(in_ready),
    .wr_valid_o(wr_valid),
    .hdr_we_o  (hdr_we),
    .hdr_clr_o (hdr_clr),
    .done_o    (frag_done)
  );

  canfrag_hdr_store #(.HDR_BYTES(HDR_BYTES), .IW(IW)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (hdr_we),
    .wr_idx_i (off_q[IW-1:0]),
    .wr_byte_i(in_data),
    .clr_i    (hdr_clr),
    .rd_idx_i (off_q[IW-1:0]),
    .rd_byte_o(hdr_byte)
  );

  assign wr_data       = (phase == PH_RPL) ? hdr_byte : in_data;
  assign wr_offset     = off_q;
  assign next_offset_o = off_q;
endmodule

// File: rtl/canfrag_chk.sv
module canfrag_chk #(
  parameter int MIN_SIZE = 16,
  parameter int MAX_SIZE = 72,
  parameter int CW       = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [CW-1:0] wr_offset,
  input logic [7:0]    wr_data,
  input logic          in_ready,
  input logic          in_last,
  input logic          frag_done,
  input logic [CW-1:0] size_eff,
  input logic          in_pkt
);
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset) && $stable(wr_data)));

  assert_size_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt |-> (size_eff >= CW'(MIN_SIZE) && size_eff <= CW'(MAX_SIZE)));

  assert_offset_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_offset < size_eff));

  assert_offset_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(in_ready && in_last) && (wr_offset != size_eff - CW'(1)))
    |=> (wr_offset == $past(wr_offset) + CW'(1)));

  assert_done_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frag_done |-> (wr_offset == '0 && $past(wr_valid && wr_ready)));

  assert_size_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && $past(in_pkt)) |-> $stable(size_eff));
endmodule

bind canfrag_top canfrag_chk #(.MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_offset(wr_offset),
  .wr_data  (wr_data),
  .in_ready (in_ready),
  .in_last  (in_last),
  .frag_done(frag_done),
  .size_eff (size_eff),
  .in_pkt   (in_pkt)
);

// File: tb/canfrag_top_tb.sv
module canfrag_top_tb;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] buf_size_i = 12'd16;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [6:0]  wr_offset;
  logic [7:0]  wr_data;
  logic        frag_done;
  logic [6:0]  next_offset_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_done = 0;
  int seen_done = 0;
  int cyc_n = 0;
  bit finished = 0;
  bit mon_on = 0;

  // entry: {replay, last_of_frag, offset[6:0], data[7:0]}
  logic [16:0] exp_q[$];

  always #(CLK_T/2) clk = ~clk;

  canfrag_top u_dut (
    .clk(clk), .rst_n(rst_n), .buf_size_i(buf_size_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_offset(wr_offset), .wr_data(wr_data),
    .frag_done(frag_done), .next_offset_o(next_offset_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(input int k, input int seed);
    if (k < 8) return 8'(seed + k * 17);
    return 8'((k * 13) ^ seed);
  endfunction

  // Back-pressure: two stalled cycles out of every seven.
  always @(negedge clk) begin
    cyc_n++;
    wr_ready = ((cyc_n % 7) < 5);
  end

  // Driver: builds the expected buffer writes, then streams the packet.
  task automatic send_pkt(input int n, input int s, input int s_after, input int seed);
    int c, off;
    c = (s < 16) ? 16 : (s > 72) ? 72 : s;
    off = 0;
    for (int k = 0; k < n; k++) begin
      bit lst;
      if (off == 0 && k >= 8) begin
        for (int h = 0; h < 8; h++) exp_q.push_back({1'b1, 1'b0, 7'(h), pkt_byte(h, seed)});
        off = 8;
      end
      lst = (k == n - 1) || (off == c - 1);
      if (lst) exp_done++;
      exp_q.push_back({1'b0, lst, 7'(off), pkt_byte(k, seed)});
      off = (off == c - 1) ? 0 : off + 1;
    end
    buf_size_i = 12'(s);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 1) buf_size_i = 12'(s_after);
      in_valid = 1'b1;
      in_data  = pkt_byte(k, seed);
      in_last  = (k == n - 1);
      #(CLK_T/4);
      while (!in_ready) begin
        @(negedge clk);
        #(CLK_T/4);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every accepted write.
  logic       pend_done = 0;
  logic       prev_stall = 0;
  logic [6:0] prev_off;
  logic [7:0] prev_dat;
  always begin
    @(negedge clk);
    #(CLK_T/4);
    if (mon_on) begin
      if (pend_done) chk(frag_done === 1'b1, "R5/R7", "frag_done after final byte", frag_done, 1);
      else if (frag_done !== 1'b0) chk(0, "R5", "unexpected frag_done", frag_done, 0);
      if (frag_done) seen_done++;
      if (prev_stall)
        chk(wr_valid && wr_offset == prev_off && wr_data == prev_dat, "R2",
            "stalled write changed", int'({wr_offset, wr_data}), int'({prev_off, prev_dat}));
      pend_done = 0;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) chk(0, "R4", "write with empty scoreboard", wr_offset, -1);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk(wr_offset == e[14:8], "R4/R6", "write offset", wr_offset, e[14:8]);
          chk(wr_data == e[7:0], "R4/R6", "write data", wr_data, e[7:0]);
          chk(next_offset_o == e[14:8], "R10", "next offset", next_offset_o, e[14:8]);
          if (e[16]) chk(in_ready == 1'b0, "R6", "in_ready during replay", in_ready, 0);
          pend_done = e[15];
        end
      end else if (!wr_valid && frag_done)
        chk(next_offset_o == 0, "R10", "offset after fragment", next_offset_o, 0);
      prev_stall = wr_valid && !wr_ready;
      prev_off = wr_offset;
      prev_dat = wr_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_valid == 0, "R1", "wr_valid in reset", wr_valid, 0);
    chk(frag_done == 0, "R1", "frag_done in reset", frag_done, 0);
    chk(next_offset_o == 0, "R1", "next offset in reset", next_offset_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    // R4 R5 R6: size 20, payload 22 bytes -> fragments of 20 and 18
    send_pkt(30, 20, 20, 8'h31);
    // R3: size 4 clamps to 16
    send_pkt(28, 4, 4, 8'h52);
    // R3 R7: size 100 clamps to 72, last byte exactly fills the buffer
    send_pkt(72, 100, 100, 8'h17);
    // R7: fresh header on the next packet
    send_pkt(78, 100, 100, 8'hA4);
    // R8: size raised mid-packet is ignored
    send_pkt(38, 20, 60, 8'h6E);
    // R9: packet shorter than the header
    send_pkt(3, 16, 16, 8'hC9);
    // R7: header-only packet
    send_pkt(8, 30, 30, 8'h0B);
    chk(seen_done == exp_done, "R5/R7", "fragment count", seen_done, exp_done);
    chk(exp_q.size() == 0, "R4", "writes outstanding", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule